// File: doc/BRIEF.md
# PLL Fast-Lock Bandwidth Sequencer

This controller runs on the synthesizer reference clock and shapes the loop bandwidth after a channel change. When a new channel is programmed, the loop filter resistor switches close and every charge-pump cell is enabled, which puts the loop into its wide, fast-settling mode. After a programmable number of reference cycles, the pump current is halved in a fixed, timed ladder until a single cell is left. At that point the resistor switches open and the loop returns to its narrow, low-noise mode.

Each halving of the pump current is announced one reference cycle ahead by a scale-request pulse to the sigma-delta modulator. The modulator uses that pulse to double its internal state, so the next phase-detector pulse is twice as wide and makes up for the halved current. The enable bus is thermometer coded: cell 0 is always on, and it is the one cell that remains under phase-detector control in narrow mode.

Top module: `fls_top`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, `cell_en_o` has only bit 0 set, and `rsw_close_o`, `busy_o` and `scale_req_o` are 0.
- R2: A cycle with `chan_new_i` high sets all `NUM_CELLS` bits of `cell_en_o`, `rsw_close_o` and `busy_o` to 1 from the next cycle on.
- R3: The full-strength level lasts `timeout_i + STEP_CYC` cycles, where `timeout_i` is sampled with the strobe.
- R4: After the full-strength level, the number of enabled cells halves (64, 32, 16, 8, 4, 2, 1) every `STEP_CYC` cycles. `cell_en_o` changes at no other time except on a strobe.
- R5: `scale_req_o` is high for exactly one cycle, the last cycle of each level above one cell, which gives six pulses per sequence. It is low at all other times.
- R6: `rsw_close_o` and `busy_o` fall on the same edge at which `cell_en_o` reaches the single-cell value, and never while more than one cell is enabled.
- R7: A strobe during a running sequence restarts it from the full-strength level with the newly sampled timeout.
- R8: With `timeout_i` = 0 the hold is skipped, and the first halving step starts in the cycle right after the strobe.
- R9: `cell_en_o` is always a thermometer code (bit i set means every lower bit is set), and bit 0 is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_new_i | input | 1 | New-channel strobe, one cycle |
| timeout_i | input | TMO_W | Hold length in reference cycles, sampled with the strobe |
| cell_en_o | output | NUM_CELLS | Thermometer enable for the charge-pump cells |
| rsw_close_o | output | 1 | 1 closes the loop-filter resistor switches |
| busy_o | output | 1 | Wide-band sequence in progress |
| scale_req_o | output | 1 | Modulator state-scale request, one cycle before each halving |

## Verification
The bench builds the block with `NUM_CELLS` = 64, `STEP_CYC` = 4 and `TMO_W` = 8. With these values the full six-step ladder, the all-ones thermometer word and the largest timeout (255) all fit in a short run. The timeouts 0, 1, 7 and 255 move the first halving edge across the whole hold range. A restart strobe is placed inside the hold and another inside the ladder, which exercises the restart from both phases.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_STEP = 2'd2
  } fls_phase_e;
endpackage

// File: rtl/fls_seq_fsm.sv
module fls_seq_fsm
  import fls_pkg::*;
#(
  parameter int STEPS    = 6,
  parameter int STEP_CYC = 4,
  parameter int TMO_W    = 16,
  parameter int LVL_W    = $clog2(STEPS + 1),
  parameter int CNT_W    = (TMO_W > $clog2(STEP_CYC + 1)) ? TMO_W : $clog2(STEP_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chan_new_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic [LVL_W-1:0] level_o,
  output logic             active_o,
  output logic             scale_req_o
);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(STEPS);
  localparam logic [CNT_W-1:0] STEP_RLD = CNT_W'(STEP_CYC - 1);

  fls_phase_e       phase_q, phase_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    lvl_d   = lvl_q;
    cnt_d   = cnt_q;
    if (chan_new_i) begin
      lvl_d = '0;
      if (timeout_i == '0) begin
        phase_d = PH_STEP;
        cnt_d   = STEP_RLD;
      end else begin
        phase_d = PH_HOLD;
        cnt_d   = CNT_W'(timeout_i) - CNT_W'(1);
      end
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          if (cnt_zero) begin
            phase_d = PH_STEP;
            cnt_d   = STEP_RLD;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        PH_STEP: begin
          if (cnt_zero) begin
            lvl_d = lvl_q + LVL_W'(1);
            cnt_d = STEP_RLD;
            if (lvl_q == LVL_LAST - LVL_W'(1)) begin
              phase_d = PH_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        default: begin
          phase_d = PH_IDLE;
          lvl_d   = LVL_LAST;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      lvl_q   <= LVL_LAST;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o     = lvl_q;
  assign active_o    = (phase_q != PH_IDLE);
  assign scale_req_o = (phase_q == PH_STEP) && cnt_zero;

  // R5
  scale_in_ladder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_req_o |-> (lvl_q < LVL_LAST));

  // R6
  idle_at_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> (lvl_q == LVL_LAST));
endmodule

// File: rtl/fls_therm_enc.sv
module fls_therm_enc #(
  parameter int NUM_CELLS = 64,
  parameter int STEPS     = $clog2(NUM_CELLS),
  parameter int LVL_W     = $clog2(STEPS + 1)
) (
  input  logic [LVL_W-1:0]     level_i,
  output logic [NUM_CELLS-1:0] en_o
);
  localparam int CELL_W = $clog2(NUM_CELLS) + 1;

  logic [CELL_W-1:0] cells;

  always_comb begin
    if (int'(level_i) >= STEPS) cells = CELL_W'(1);
    else                        cells = CELL_W'(NUM_CELLS >> level_i);
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    if (i == 0) begin : g_floor
      assign en_o[i] = 1'b1;
    end else begin : g_upper
      assign en_o[i] = (CELL_W'(i) < cells);
    end
  end
endmodule

// File: rtl/fls_top.sv
module fls_top #(
  parameter int NUM_CELLS = 64,
  parameter int STEP_CYC  = 4,
  parameter int TMO_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 chan_new_i,
  input  logic [TMO_W-1:0]     timeout_i,
  output logic [NUM_CELLS-1:0] cell_en_o,
  output logic                 rsw_close_o,
  output logic                 busy_o,
  output logic                 scale_req_o
);
  localparam int STEPS = $clog2(NUM_CELLS);
  localparam int LVL_W = $clog2(STEPS + 1);

  logic [LVL_W-1:0] level;
  logic             active;

  fls_seq_fsm #(
    .STEPS   (STEPS),
    .STEP_CYC(STEP_CYC),
    .TMO_W   (TMO_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_new_i (chan_new_i),
    .timeout_i  (timeout_i),
    .level_o    (level),
    .active_o   (active),
    .scale_req_o(scale_req_o)
  );

  fls_therm_enc #(
    .NUM_CELLS(NUM_CELLS),
    .STEPS    (STEPS)
  ) u_enc (
    .level_i(level),
    .en_o   (cell_en_o)
  );

  assign rsw_close_o = active;
  assign busy_o      = active;

  // R9
  floor_cell_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_en_o[0] && ((cell_en_o & (cell_en_o + NUM_CELLS'(1))) == '0));

  // R2
  strobe_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_new_i |=> (&cell_en_o) && rsw_close_o && busy_o);

  // R5
  scale_halves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_req_o && !chan_new_i) |=>
      ($countones(cell_en_o) * 2 == $countones($past(cell_en_o))));

  // R4
  en_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scale_req_o && !chan_new_i) |=> $stable(cell_en_o));

  // R6
  open_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsw_close_o |-> (cell_en_o == NUM_CELLS'(1)));
endmodule

// File: tb/tb_fls_top.sv
module tb_fls_top;
  localparam int NC  = 64;
  localparam int SC  = 4;
  localparam int TW  = 8;
  localparam int NST = 6;

  typedef struct {
    logic [NC-1:0] en;
    logic          rsw;
    logic          busy;
    logic          scale;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chan_new;
  logic [TW-1:0] tmo;
  logic [NC-1:0] cell_en;
  logic          rsw_close, busy, scale_req;

  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t q[$];

  fls_top #(.NUM_CELLS(NC), .STEP_CYC(SC), .TMO_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .chan_new_i(chan_new), .timeout_i(tmo),
    .cell_en_o(cell_en), .rsw_close_o(rsw_close), .busy_o(busy),
    .scale_req_o(scale_req)
  );

  always #4 clk = ~clk;

  function automatic logic [NC-1:0] therm(int cells);
    logic [NC-1:0] v = '0;
    for (int i = 0; i < cells; i++) v[i] = 1'b1;
    return v;
  endfunction

  // Expected outputs m edges after the strobe edge, timeout t
  function automatic exp_t model(int m, int t, string pre);
    exp_t e;
    int lvl;
    if (m < t + SC) lvl = 0;
    else lvl = 1 + (m - t - SC) / SC;
    if (lvl > NST) lvl = NST;
    e.en    = therm(NC >> lvl);
    e.rsw   = (lvl < NST);
    e.busy  = (lvl < NST);
    e.scale = (lvl < NST) && (m >= t + SC - 1) && (((m - t + 1) % SC) == 0);
    if (m == 0)          e.tag = {pre, "R2"};
    else if (lvl == 0)   e.tag = {pre, "R3"};
    else if (lvl < NST)  e.tag = {pre, "R4"};
    else                 e.tag = {pre, "R6"};
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_vec++;
    if (cell_en !== e.en || cell_en[0] !== 1'b1) begin
      n_fail++;
      $display("FAIL %s/R9 cell_en got %h exp %h", e.tag, cell_en, e.en);
    end else if (rsw_close !== e.rsw || busy !== e.busy) begin
      n_fail++;
      $display("FAIL %s rsw/busy got %b%b exp %b%b", e.tag, rsw_close, busy, e.rsw, e.busy);
    end else if (scale_req !== e.scale) begin
      n_fail++;
      $display("FAIL R5 (%s) scale_req got %b exp %b", e.tag, scale_req, e.scale);
    end
  endtask

  // Monitor: one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  // Driver: strobe with timeout t, expect ncyc cycles
  task automatic run_seq(int t, int ncyc, string pre);
    @(negedge clk);
    chan_new = 1'b1;
    tmo      = TW'(t);
    @(posedge clk);
    for (int m = 0; m < ncyc; m++) q.push_back(model(m, t, pre));
    #1 chan_new = 1'b0;
    tmo = '1;
    repeat (ncyc - 1) @(posedge clk);
  endtask

  initial begin
    exp_t r;
    rst_n    = 1'b0;
    chan_new = 1'b0;
    tmo      = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    r.en = therm(1); r.rsw = 0; r.busy = 0; r.scale = 0; r.tag = "R1";
    compare(r);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release, no strobe
    compare(r);

    run_seq(7,   40,  "");
    run_seq(1,   32,  "");
    run_seq(0,   30,  "R8/");
    run_seq(255, 285, "");
    // R7: restart inside the hold, then inside the ladder
    run_seq(10,  6,   "R7/");
    run_seq(3,   12,  "R7/");
    run_seq(2,   34,  "R7/");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule